// File: doc/BRIEF.md
# Fan Tachometer Capture Timer

This block measures the speed of up to two fans at once. Each of its two channels owns a 16-bit down-counter that advances on a tick from a shared programmable prescaler. When the selected edge arrives on the channel's chosen tachometer pin, the running count is copied into that channel's capture register and the counter restarts from all ones. Software works out the interval between tach pulses as 0xFFFF minus the captured count.

Each channel can pick one of two tach pins, and each pin passes through a synchronizer before edge detection. A channel also reports an underflow when no pulse arrives before the count runs out. Through a 4-bit compare setting, a channel can halt its measurement early, at all ones, at a compare value, or one below it. Six pending flags, a matching enable mask and a write-one-to-clear register drive one level interrupt. Software reaches all of this through a small byte/halfword register port.

Top module: `fan_tach_timer`

## Requirements
- R1: Register offsets are MODE 0x00, DIV 0x02, CLKEN 0x04, PEND 0x06 (read-only), PCLR 0x08 (write-only), IRQEN 0x0A, CMPCFG 0x0C, SRC_A 0x0E, SRC_B 0x10 (byte access, `bus_half`=0), and CNT_A 0x12, CAP_A 0x14 (read-only), CMP_A 0x16, CNT_B 0x18, CAP_B 0x1A (read-only), CMP_B 0x1C (halfword access, `bus_half`=1). An access of the wrong size or to any other offset raises `bus_err`, reads as zero and changes nothing.
- R2: A channel's counter moves down by one every DIV+1 clocks, and only while MODE bit 2, the channel enable (MODE bit 5 for A, bit 6 for B) and the channel clock select (CLKEN bit 0 for A, bit 3 for B) are all set. The prescaler phase restarts whenever both clock selects are clear.
- R3: A valid edge on a running channel copies the count into CAP_A/CAP_B, sets PEND bit 0 (A) or bit 1 (B), and reloads the counter to 0xFFFF. The edge reaches the counter three clocks after the pin changes.
- R4: The edge bit (MODE bit 3 for A, bit 4 for B) selects a rising edge when 1 and a falling edge when 0. The other edge direction causes no capture.
- R5: Bit 0 of SRC_A/SRC_B selects pin 1 when set and pin 0 when clear. Pulses on the other pin are ignored.
- R6: A tick that finds the count at zero sets PEND bit 2 (A) or bit 3 (B) and reloads 0xFFFF.
- R7: CMPCFG bits [3:0] serve channel A and bits [7:4] serve channel B. Within a nibble, bit 3 (stop at 0xFFFF) outranks bit 2 (stop at the compare value), which outranks bit 1 (stop at compare minus one). Only the highest enabled condition is tested. A hit sets PEND bit 4 (A) or bit 5 (B) and freezes the counter until software writes its CNT register.
- R8: With only the below-compare condition enabled and a compare value of zero, no compare hit ever occurs.
- R9: `irq` is high exactly when some PEND bit and the IRQEN bit at the same position are both set.
- R10: Writing 1 to a PCLR bit clears the PEND bit at the same position. PCLR reads as zero.
- R11: Reset clears MODE, DIV, CLKEN, PEND, IRQEN, CMPCFG, SRC_A/B and CMP_A/B, and drops `irq`. CNT and CAP registers keep their values across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational |
| bus_err | output | 1 | Access rejected (size or offset) |
| tach_a | input | 2 | Tachometer pins selectable by channel A |
| tach_b | input | 2 | Tachometer pins selectable by channel B |
| irq | output | 1 | Combined level interrupt |

## Verification
The bound checker watches the invariants on every cycle: a counter that is idle or halted by a compare hit never moves; a running counter only holds, steps down by one or reloads; a pending flag falls only after a matching clear write; a rise of `irq` comes from a newly set flag or a newly set enable bit; and a halfword access to a byte register is always rejected. The exact captured counts, the edge polarity and input selection, the priority among the three compare conditions, the zero-compare corner, and the registers that keep their values across reset depend on timed pin stimulus and register sequences. Only the directed scenarios in the bench can show these.

// File: rtl/tach_pkg.sv
package tach_pkg;
   localparam int N_CH   = 2;
   localparam int N_PEND = 6;

   localparam logic [4:0] ADR_MODE  = 5'h00;
   localparam logic [4:0] ADR_DIV   = 5'h02;
   localparam logic [4:0] ADR_CLKEN = 5'h04;
   localparam logic [4:0] ADR_PEND  = 5'h06;
   localparam logic [4:0] ADR_PCLR  = 5'h08;
   localparam logic [4:0] ADR_IRQEN = 5'h0A;
   localparam logic [4:0] ADR_CFG   = 5'h0C;
   localparam logic [4:0] ADR_SRC [N_CH] = '{5'h0E, 5'h10};
   localparam logic [4:0] ADR_CNT [N_CH] = '{5'h12, 5'h18};
   localparam logic [4:0] ADR_CAP [N_CH] = '{5'h14, 5'h1A};
   localparam logic [4:0] ADR_CMP [N_CH] = '{5'h16, 5'h1C};

   // MODE register bit positions (per-channel bits are base + channel)
   localparam int MB_GO  = 2;
   localparam int MB_POL = 3;
   localparam int MB_EN  = 5;
   // CLKEN bit per channel
   localparam int CK_BIT [N_CH] = '{0, 3};

   function automatic logic is_byte_reg(input logic [4:0] a);
      case (a)
         ADR_MODE, ADR_DIV, ADR_CLKEN, ADR_PEND, ADR_PCLR,
         ADR_IRQEN, ADR_CFG, ADR_SRC[0], ADR_SRC[1]: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic is_half_reg(input logic [4:0] a);
      case (a)
         ADR_CNT[0], ADR_CNT[1], ADR_CAP[0], ADR_CAP[1],
         ADR_CMP[0], ADR_CMP[1]: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)      st[s] <= '0;
         else if (s == 0) st[s] <= d;
         else             st[s] <= st[(s == 0) ? 0 : s-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] pre_q;

   // ">=" keeps the period sane if DIV shrinks mid-count
   assign tick = active && (pre_q >= div);

   always_ff @(posedge clk) begin
      if (!rst_n || !active) pre_q <= '0;
      else if (tick)         pre_q <= '0;
      else                   pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/tach_channel.sv
module tach_channel #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             pol,
   input  logic             src,
   input  logic [1:0]       tach,
   input  logic [CNT_W-1:0] cmp,
   input  logic [3:0]       cfg,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap,
   output logic             ev_cap,
   output logic             ev_unf,
   output logic             ev_cmp,
   output logic             stopped
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic cur, prev_q, edge_seen, hit, run_ok;
   logic [CNT_W-1:0] cnt_q, cap_q;
   logic stop_q;

   assign cur       = tach[src];
   assign edge_seen = pol ? (cur & ~prev_q) : (~cur & prev_q);

   // only the highest enabled stop condition is evaluated
   always_comb begin
      if (cfg[3])      hit = (cnt_q == CNT_MAX);
      else if (cfg[2]) hit = (cnt_q == cmp);
      else if (cfg[1]) hit = (cmp != '0) && (cnt_q == cmp - 1'b1);
      else             hit = 1'b0;
   end

   assign run_ok = run & ~stop_q;
   assign ev_cap = run_ok & edge_seen;
   assign ev_cmp = run_ok & ~edge_seen & hit;
   assign ev_unf = run_ok & ~edge_seen & ~hit & tick & (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      stop_q <= 1'b0;
      else if (ld)     stop_q <= 1'b0;
      else if (ev_cmp) stop_q <= 1'b1;
   end

   // count and capture registers deliberately survive reset
   always_ff @(posedge clk) begin
      if (ld)                         cnt_q <= ld_val;
      else if (ev_cap || ev_unf)      cnt_q <= CNT_MAX;
      else if (ev_cmp)                cnt_q <= cnt_q;
      else if (run_ok && tick)        cnt_q <= cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (ev_cap) cap_q <= cnt_q;
   end

   assign cnt     = cnt_q;
   assign cap     = cap_q;
   assign stopped = stop_q;
endmodule

// File: rtl/fan_tach_timer.sv
module fan_tach_timer
   import tach_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic             bus_half,
   input  logic [4:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   output logic             bus_err,
   input  logic [1:0]       tach_a,
   input  logic [1:0]       tach_b,
   output logic             irq
);
   localparam int N_PIN = 2 * N_CH;

   if (CNT_W < 8) begin : g_bad_cnt
      $error("CNT_W must be at least 8");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("DIV_W must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic acc_ok, wr_en;
   logic [7:0]        mode_q, clken_q, cfg_q;
   logic [DIV_W-1:0]  div_q;
   logic [N_PEND-1:0] pend_q, irqen_q, clr_m, set_m;
   logic [N_CH-1:0]   src_q;
   logic [CNT_W-1:0]  cmp_q [N_CH];
   logic [CNT_W-1:0]  cnt_v [N_CH];
   logic [CNT_W-1:0]  cap_v [N_CH];
   logic [N_CH-1:0]   run_v, stop_v, ld_v, ev_cap_v, ev_unf_v, ev_cmp_v;
   logic [N_PIN-1:0]  tach_s;
   logic              tick;

   assign acc_ok  = bus_half ? is_half_reg(bus_addr) : is_byte_reg(bus_addr);
   assign bus_err = bus_sel & ~acc_ok;
   assign wr_en   = bus_sel & bus_wr & acc_ok;

   // ---------------- configuration and status registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= '0;
         div_q   <= '0;
         clken_q <= '0;
         irqen_q <= '0;
         cfg_q   <= '0;
         src_q   <= '0;
         pend_q  <= '0;
         for (int c = 0; c < N_CH; c++) cmp_q[c] <= '0;
      end else begin
         if (wr_en) begin
            case (bus_addr)
               ADR_MODE:   mode_q   <= bus_wdata[7:0];
               ADR_DIV:    div_q    <= bus_wdata[DIV_W-1:0];
               ADR_CLKEN:  clken_q  <= bus_wdata[7:0];
               ADR_IRQEN:  irqen_q  <= bus_wdata[N_PEND-1:0];
               ADR_CFG:    cfg_q    <= bus_wdata[7:0];
               ADR_SRC[0]: src_q[0] <= bus_wdata[0];
               ADR_SRC[1]: src_q[1] <= bus_wdata[0];
               ADR_CMP[0]: cmp_q[0] <= bus_wdata;
               ADR_CMP[1]: cmp_q[1] <= bus_wdata;
               default: ;
            endcase
         end
         // a new event wins over a clear aimed at the same bit
         pend_q <= (pend_q & ~clr_m) | set_m;
      end
   end

   assign clr_m = (wr_en && bus_addr == ADR_PCLR) ? bus_wdata[N_PEND-1:0] : '0;
   assign set_m = {ev_cmp_v, ev_unf_v, ev_cap_v};
   assign irq   = |(pend_q & irqen_q);

   // ---------------- read path
   always_comb begin
      bus_rdata = '0;
      if (bus_sel && acc_ok) begin
         case (bus_addr)
            ADR_MODE:   bus_rdata[7:0]        = mode_q;
            ADR_DIV:    bus_rdata[DIV_W-1:0]  = div_q;
            ADR_CLKEN:  bus_rdata[7:0]        = clken_q;
            ADR_PEND:   bus_rdata[N_PEND-1:0] = pend_q;
            ADR_IRQEN:  bus_rdata[N_PEND-1:0] = irqen_q;
            ADR_CFG:    bus_rdata[7:0]        = cfg_q;
            ADR_SRC[0]: bus_rdata[0]          = src_q[0];
            ADR_SRC[1]: bus_rdata[0]          = src_q[1];
            ADR_CNT[0]: bus_rdata             = cnt_v[0];
            ADR_CNT[1]: bus_rdata             = cnt_v[1];
            ADR_CAP[0]: bus_rdata             = cap_v[0];
            ADR_CAP[1]: bus_rdata             = cap_v[1];
            ADR_CMP[0]: bus_rdata             = cmp_q[0];
            ADR_CMP[1]: bus_rdata             = cmp_q[1];
            default:    bus_rdata             = '0;
         endcase
      end
   end

   // ---------------- shared datapath
   tach_sync #(.W(N_PIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({tach_b, tach_a}),
      .q     (tach_s)
   );

   tach_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (clken_q[CK_BIT[0]] | clken_q[CK_BIT[1]]),
      .div    (div_q),
      .tick   (tick)
   );

   for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
      assign run_v[gi] = mode_q[MB_GO] & mode_q[MB_EN+gi] & clken_q[CK_BIT[gi]];
      assign ld_v[gi]  = wr_en && (bus_addr == ADR_CNT[gi]);

      tach_channel #(.CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run_v[gi]),
         .tick    (tick),
         .pol     (mode_q[MB_POL+gi]),
         .src     (src_q[gi]),
         .tach    (tach_s[2*gi +: 2]),
         .cmp     (cmp_q[gi]),
         .cfg     (cfg_q[4*gi +: 4]),
         .ld      (ld_v[gi]),
         .ld_val  (bus_wdata),
         .cnt     (cnt_v[gi]),
         .cap     (cap_v[gi]),
         .ev_cap  (ev_cap_v[gi]),
         .ev_unf  (ev_unf_v[gi]),
         .ev_cmp  (ev_cmp_v[gi]),
         .stopped (stop_v[gi])
      );
   end
endmodule

// File: rtl/tach_timer_chk.sv
module tach_timer_chk
   import tach_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_sel,
   input logic                        bus_wr,
   input logic                        bus_half,
   input logic [4:0]                  bus_addr,
   input logic [N_PEND-1:0]           bus_wdata,
   input logic                        bus_err,
   input logic                        irq,
   input logic [N_PEND-1:0]           pend,
   input logic [N_PEND-1:0]           irqen,
   input logic [N_CH-1:0]             run,
   input logic [N_CH-1:0]             stop,
   input logic [N_CH-1:0][CNT_W-1:0]  cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic              wr_ok;
   logic [N_PEND-1:0] clr;
   logic [N_CH-1:0]   ld;

   assign wr_ok = bus_sel & bus_wr & ~bus_err;
   assign clr   = (wr_ok && bus_addr == ADR_PCLR) ? bus_wdata : '0;
   for (genvar c = 0; c < N_CH; c++) begin : g_ld
      assign ld[c] = wr_ok && bus_half && (bus_addr == ADR_CNT[c]);
   end

   // R1: a halfword access to a byte register is rejected
   assert_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_half && is_byte_reg(bus_addr)) |-> bus_err);

   // R9: interrupt only rises with a new flag or a new enable
   assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (((pend & ~$past(pend)) != '0) || ((irqen & ~$past(irqen)) != '0)));

   for (genvar i = 0; i < N_PEND; i++) begin : g_pend
      // R10: a flag falls only after a write-one-to-clear of that bit
      assert_pend_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pend[i]) |-> $past(clr[i]));
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_cnt
      // R2: an idle channel's counter holds
      assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!run[c] && !ld[c]) |=> $stable(cnt[c]));
      // R2: a running counter holds, steps by one or reloads
      assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (run[c] && !ld[c]) |=> ((cnt[c] == $past(cnt[c])) ||
                                 (cnt[c] == CNT_W'($past(cnt[c]) - 1'b1)) ||
                                 (cnt[c] == CNT_MAX)));
      // R7: a compare hit freezes the counter until it is rewritten
      assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (stop[c] && !ld[c]) |=> $stable(cnt[c]));
   end
endmodule

bind fan_tach_timer tach_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_half  (bus_half),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata[5:0]),
   .bus_err   (bus_err),
   .irq       (irq),
   .pend      (pend_q),
   .irqen     (irqen_q),
   .run       (run_v),
   .stop      (stop_v),
   .cnt       ({cnt_v[1], cnt_v[0]})
);

// File: tb/fan_tach_timer_tb.sv
module fan_tach_timer_tb;
   localparam logic [4:0] A_MODE  = 5'h00, A_DIV   = 5'h02, A_CLKEN = 5'h04,
                          A_PEND  = 5'h06, A_PCLR  = 5'h08, A_IRQEN = 5'h0A,
                          A_CFG   = 5'h0C, A_SRCB  = 5'h10,
                          A_CNTA  = 5'h12, A_CAPA  = 5'h14, A_CMPA  = 5'h16,
                          A_CNTB  = 5'h18, A_CAPB  = 5'h1A, A_CMPB  = 5'h1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_half = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_err;
   logic [1:0]  tach_a = '0, tach_b = '0;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fan_tach_timer u_dut (
      .clk (clk), .rst_n (rst_n),
      .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_half (bus_half),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata), .bus_err (bus_err),
      .tach_a (tach_a), .tach_b (tach_b), .irq (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic half, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_half = half; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic half,
                     output logic [15:0] d, output logic e);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_half = half; bus_addr = a;
      #1;
      d = bus_rdata; e = bus_err;
      bus_sel = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [4:0] a, input logic half,
                         input logic [15:0] exp);
      logic [15:0] d; logic e;
      rd(a, half, d, e);
      chk(req, d, exp);
   endtask

   task automatic do_reset();
      tach_a = '0; tach_b = '0;
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      rd_chk("R11 mode after reset", A_MODE, 1'b0, 16'h0000);
      rd_chk("R11 pend after reset", A_PEND, 1'b0, 16'h0000);
      chk("R11 irq after reset", irq, 1'b0);
      wr(A_CNTA, 1'b1, 16'h1234);
      wr(A_MODE, 1'b0, 16'h0024);
      wr(A_IRQEN, 1'b0, 16'h003F);
      do_reset();
      rd_chk("R11 CNT_A kept over reset", A_CNTA, 1'b1, 16'h1234);
      rd_chk("R11 MODE cleared", A_MODE, 1'b0, 16'h0000);
      rd_chk("R11 IRQEN cleared", A_IRQEN, 1'b0, 16'h0000);
   endtask

   task automatic t_access();
      logic [15:0] d; logic e;
      do_reset();
      rd(A_MODE, 1'b1, d, e);  chk("R1 half access to byte reg errs", e, 1'b1);
      wr(A_MODE, 1'b1, 16'h0024);
      rd_chk("R1 wrong-size write ignored", A_MODE, 1'b0, 16'h0000);
      rd(A_CNTA, 1'b0, d, e);  chk("R1 byte access to half reg errs", e, 1'b1);
      rd(5'h1E, 1'b0, d, e);   chk("R1 unlisted offset errs", e, 1'b1);
      rd(5'h01, 1'b0, d, e);   chk("R1 odd offset errs", e, 1'b1);
      rd(A_DIV, 1'b0, d, e);   chk("R1 legal byte access ok", e, 1'b0);
   endtask

   task automatic t_count();
      do_reset();
      wr(A_DIV, 1'b0, 16'd9);
      wr(A_CNTA, 1'b1, 16'h0100);
      wr(A_MODE, 1'b0, 16'h0024);
      repeat (100) @(negedge clk);
      rd_chk("R2 frozen without clock select", A_CNTA, 1'b1, 16'h0100);
      wr(A_CLKEN, 1'b0, 16'h0001);
      repeat (505) @(negedge clk);
      rd_chk("R2 fifty ticks of DIV+1=10 clocks", A_CNTA, 1'b1, 16'h00CE);
   endtask

   task automatic t_capture();
      do_reset();
      wr(A_DIV, 1'b0, 16'd99);
      wr(A_CNTA, 1'b1, 16'h1000);
      wr(A_MODE, 1'b0, 16'h002C);
      wr(A_IRQEN, 1'b0, 16'h0001);
      wr(A_CLKEN, 1'b0, 16'h0001);
      repeat (349) @(negedge clk);
      tach_a[0] = 1'b1;
      repeat (10) @(negedge clk);
      rd_chk("R3 captured count", A_CAPA, 1'b1, 16'h0FFD);
      rd_chk("R3 capture flag bit0", A_PEND, 1'b0, 16'h0001);
      chk("R9 irq with flag and enable", irq, 1'b1);
      rd_chk("R3 counter reloaded", A_CNTA, 1'b1, 16'hFFFF);
      tach_a[0] = 1'b0;
      repeat (10) @(negedge clk);
      rd_chk("R4 falling edge ignored when rising chosen", A_CAPA, 1'b1, 16'h0FFD);
      wr(A_IRQEN, 1'b0, 16'h0000);
      chk("R9 irq masked", irq, 1'b0);
      wr(A_IRQEN, 1'b0, 16'h0001);
      chk("R9 irq unmasked", irq, 1'b1);
      wr(A_PCLR, 1'b0, 16'h0001);
      rd_chk("R10 flag cleared", A_PEND, 1'b0, 16'h0000);
      chk("R10 irq drops after clear", irq, 1'b0);
      rd_chk("R10 PCLR reads zero", A_PCLR, 1'b0, 16'h0000);
   endtask

   task automatic t_select();
      do_reset();
      tach_b[1] = 1'b1;
      repeat (5) @(negedge clk);
      wr(A_DIV, 1'b0, 16'd99);
      wr(A_CNTB, 1'b1, 16'h2000);
      wr(A_SRCB, 1'b0, 16'h0001);
      wr(A_MODE, 1'b0, 16'h0044);
      wr(A_CLKEN, 1'b0, 16'h0008);
      repeat (49) @(negedge clk);
      tach_b[0] = 1'b1;
      repeat (5) @(negedge clk);
      tach_b[0] = 1'b0;
      repeat (5) @(negedge clk);
      rd_chk("R5 unselected pin ignored", A_PEND, 1'b0, 16'h0000);
      repeat (89) @(negedge clk);
      tach_b[1] = 1'b0;
      repeat (10) @(negedge clk);
      rd_chk("R4 falling edge captured on B", A_PEND, 1'b0, 16'h0002);
      rd_chk("R5 count from selected pin", A_CAPB, 1'b1, 16'h1FFF);
   endtask

   task automatic t_underflow();
      do_reset();
      wr(A_CFG, 1'b0, 16'h0002);
      wr(A_CNTA, 1'b1, 16'h0003);
      wr(A_MODE, 1'b0, 16'h0024);
      wr(A_CLKEN, 1'b0, 16'h0001);
      repeat (20) @(negedge clk);
      rd_chk("R6 underflow flag, R8 no hit at zero compare", A_PEND, 1'b0, 16'h0004);
   endtask

   task automatic t_compare();
      do_reset();
      wr(A_CMPA, 1'b1, 16'h0FF0);
      wr(A_CFG, 1'b0, 16'h0004);
      wr(A_CNTA, 1'b1, 16'h0FF5);
      wr(A_MODE, 1'b0, 16'h0024);
      wr(A_CLKEN, 1'b0, 16'h0001);
      repeat (30) @(negedge clk);
      rd_chk("R7 equal stop value", A_CNTA, 1'b1, 16'h0FF0);
      rd_chk("R7 compare flag bit4", A_PEND, 1'b0, 16'h0010);
      repeat (30) @(negedge clk);
      rd_chk("R7 counter stays frozen", A_CNTA, 1'b1, 16'h0FF0);

      do_reset();
      wr(A_CMPA, 1'b1, 16'h0FF0);
      wr(A_CFG, 1'b0, 16'h0002);
      wr(A_CNTA, 1'b1, 16'h0FF5);
      wr(A_MODE, 1'b0, 16'h0024);
      wr(A_CLKEN, 1'b0, 16'h0001);
      repeat (30) @(negedge clk);
      rd_chk("R7 below-compare stop value", A_CNTA, 1'b1, 16'h0FEF);

      do_reset();
      wr(A_CMPA, 1'b1, 16'h0100);
      wr(A_CFG, 1'b0, 16'h000A);
      wr(A_CNTA, 1'b1, 16'h0003);
      wr(A_MODE, 1'b0, 16'h0024);
      wr(A_CLKEN, 1'b0, 16'h0001);
      repeat (30) @(negedge clk);
      rd_chk("R7 high stop outranks low", A_CNTA, 1'b1, 16'hFFFF);
      rd_chk("R7 underflow then high hit flags", A_PEND, 1'b0, 16'h0014);

      do_reset();
      wr(A_CMPB, 1'b1, 16'h0800);
      wr(A_CFG, 1'b0, 16'h0040);
      wr(A_CNTB, 1'b1, 16'h0805);
      wr(A_MODE, 1'b0, 16'h0044);
      wr(A_CLKEN, 1'b0, 16'h0008);
      repeat (30) @(negedge clk);
      rd_chk("R7 channel B equal stop", A_CNTB, 1'b1, 16'h0800);
      rd_chk("R7 channel B compare flag bit5", A_PEND, 1'b0, 16'h0020);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_access();
      t_count();
      t_capture();
      t_select();
      t_underflow();
      t_compare();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule